// File: doc/BRIEF.md
# Codec Control Register Bank

This block is a bank of 16-bit control registers at even byte addresses. A simple synchronous register bus reaches it: an address, a write strobe with its data word, and a read strobe whose result appears on the read-data port one cycle later. Most registers hold whatever was written to them. A few apply their own write rule instead:

- one location resets the whole bank when written;
- two locations store a fixed rate constant whatever data arrives;
- one location splices a fixed four-bit pattern into the written word;
- several identification locations ignore writes altogether.

The bank also drives one decoded control bit, the operating-mode select, to the rest of the chip. The transport that carries bus cycles and any audio processing sit outside this block. A system integrator connects the bus side to whatever serial transport the chip uses and wires the mode output to the logic it steers.

Top module: `cfg_regbank`

## Requirements
- R1: A write of any data to address 00h returns every stored register to its R9 default at the next clock edge.
- R2: A read of address 00h returns 00E4h.
- R3: A write of any data to address 32h or 34h stores BB80h in that register.
- R4: A write to address 26h stores the incoming bits 15..10 and 5..0, and bits 9..6 always read back as 0111.
- R5: Address 28h reads 01C3h and ignores writes. Its set bits mean: bit 0 variable rate, bit 1 double rate, bit 6 center PCM, bit 7 surround PCM, bit 8 LFE PCM.
- R6: Address 7Ch reads 5A11h and address 7Eh reads 3C01h. Writes to either are dropped.
- R7: Address 5Ah is a full read/write register, and its bit 0 drives the output `mode_ext` (1 = extended mode, 0 = fully compliant).
- R8: Reads of any address without a register return 0000h, and writes there change no register.
- R9: While `rst_n` is low at a clock edge, `rd_data` clears to 0000h and `mode_ext` clears to 0. The stored registers load these defaults: 02h 8000h, 26h 01C0h, 2Ah 0000h, 2Ch BB80h, 32h BB80h, 34h BB80h, 36h 8080h, 38h 8080h, 5Ah 0000h.
- R10: Address bit 0 is ignored, so an odd address reaches the even register below it.
- R11: `rd_data` takes the addressed value at the clock edge where `rd_en` is high. A write in that same cycle is not yet visible to the read. `rd_data` holds its value while `rd_en` is low.
- R12: Addresses 02h, 2Ah, 2Ch, 36h and 38h store the full written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 7 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| mode_ext | output | 1 | Operating-mode select from bit 0 of 5Ah |

## Verification
The bench targets the locations whose stored value differs from the written value, and checks each failure mode directly:

- Rate registers: a design that stored the raw data at 32h/34h would read back the test pattern instead of BB80h.
- Spliced register: a wrong splice mask would either lose the written outer bits or let 0000h/FFFFh show through bits 9..6.
- Identification locations: writes to them, and to unmapped addresses, are followed by read-backs of both the target and a plain register, which exposes a design that decodes them as storage.

Soft reset is checked after every register has been dirtied, so any register missed by the soft reset shows up. Odd-address aliasing, and a read issued in the same cycle as a write, catch a design that decodes bit 0 or forwards write data early.

// File: rtl/cfg_regbank_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and per-slot write rules for the control register bank.
// Assumes byte addressing with registers only at even addresses.
package cfg_regbank_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 16;
    localparam int NUM_SLOTS = 9;
    localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {WR_PLAIN, WR_FORCE, WR_SPLICE} wr_rule_e;

    // Addresses that carry behaviour.
    localparam addr_t ADDR_SOFTRST = 7'h00;
    localparam addr_t ADDR_CAPS    = 7'h28;
    localparam addr_t ADDR_VID_HI  = 7'h7C;
    localparam addr_t ADDR_VID_LO  = 7'h7E;
    localparam addr_t ADDR_MODE    = 7'h5A;

    // Constant read values and write-rule constants.
    localparam word_t ID_WORD     = 16'h00E4;
    localparam word_t CAPS_WORD   = 16'h01C3;
    localparam word_t VID_HI_WORD = 16'h5A11;
    localparam word_t VID_LO_WORD = 16'h3C01;
    localparam word_t FORCE_WORD  = 16'hBB80;
    localparam word_t SPLICE_MASK = 16'h03C0;
    localparam word_t SPLICE_BITS = 16'h01C0;

    // Storage slots: address, reset default, write rule.
    localparam addr_t SLOT_ADDR [NUM_SLOTS] = '{
        7'h02, 7'h26, 7'h2A, 7'h2C, 7'h32, 7'h34, 7'h36, 7'h38, 7'h5A};
    localparam word_t SLOT_DEF [NUM_SLOTS] = '{
        16'h8000, 16'h01C0, 16'h0000, 16'hBB80, 16'hBB80,
        16'hBB80, 16'h8080, 16'h8080, 16'h0000};
    localparam wr_rule_e SLOT_RULE [NUM_SLOTS] = '{
        WR_PLAIN, WR_SPLICE, WR_PLAIN, WR_PLAIN, WR_FORCE,
        WR_FORCE, WR_PLAIN, WR_PLAIN, WR_PLAIN};
    localparam int MODE_SLOT = 8;
    localparam int MODE_BIT  = 0;

    // Value a slot stores when written with data d under rule r.
    function automatic word_t apply_rule(wr_rule_e r, word_t d);
        case (r)
            WR_FORCE:  return FORCE_WORD;
            WR_SPLICE: return (d & ~SPLICE_MASK) | SPLICE_BITS;
            default:   return d;
        endcase
    endfunction
endpackage

// File: rtl/cfg_regbank_decode.sv
`timescale 1ns/1ps
// Address decoder: folds odd addresses onto even ones and flags the target.
// Assumes at most one slot address matches any even address.
module cfg_regbank_decode
    import cfg_regbank_pkg::*;
(
    input  addr_t                addr,
    output addr_t                addr_even,
    output logic [NUM_SLOTS-1:0] slot_hit,
    output logic                 hit_softrst,
    output logic                 hit_caps,
    output logic                 hit_vid_hi,
    output logic                 hit_vid_lo
);
    // Drop address bit 0 so odd addresses alias the even register below.
    assign addr_even = {addr[ADDR_W-1:1], 1'b0};

    // One comparator per storage slot.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
        assign slot_hit[i] = (addr_even == SLOT_ADDR[i]);
    end

    // Fixed-value locations.
    assign hit_softrst = (addr_even == ADDR_SOFTRST);
    assign hit_caps    = (addr_even == ADDR_CAPS);
    assign hit_vid_hi  = (addr_even == ADDR_VID_HI);
    assign hit_vid_lo  = (addr_even == ADDR_VID_LO);
endmodule

// File: rtl/cfg_regbank_store.sv
`timescale 1ns/1ps
// Storage slots with per-slot write rules and soft/hard reset to defaults.
// Assumes slot_hit is one-hot or zero and never set together with soft_rst.
module cfg_regbank_store
    import cfg_regbank_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  word_t                            wr_data,
    input  logic [NUM_SLOTS-1:0]             slot_hit,
    input  logic                             soft_rst,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Hold one register; reset or apply its write rule.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                slot_q[i] <= SLOT_DEF[i];
            else if (wr_en && slot_hit[i])
                slot_q[i] <= apply_rule(SLOT_RULE[i], wr_data);
        end

        // R1: soft reset restores the default.
        assert_soft_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
            soft_rst |=> slot_q[i] == SLOT_DEF[i]);

        if (SLOT_RULE[i] == WR_FORCE) begin : g_force
            // R3: any write stores the rate constant.
            assert_forced_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && slot_hit[i] |=> slot_q[i] == FORCE_WORD);
        end else if (SLOT_RULE[i] == WR_SPLICE) begin : g_splice
            // R4: spliced field always carries the fixed pattern.
            assert_splice_field_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_q[i] & SPLICE_MASK) == SPLICE_BITS);
        end else begin : g_plain
            // R12: a plain slot stores the full written word.
            assert_plain_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && slot_hit[i] |=> slot_q[i] == $past(wr_data));
        end
    end

    // R10: the folded address selects at most one slot.
    assert_single_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hit));
endmodule

// File: rtl/cfg_regbank_rdmux.sv
`timescale 1ns/1ps
// Read-back multiplexer: constant locations, storage slots, zero elsewhere.
// Assumes the hit flags come from the same decoded address.
module cfg_regbank_rdmux
    import cfg_regbank_pkg::*;
(
    input  logic [NUM_SLOTS-1:0]             slot_hit,
    input  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q,
    input  logic                             hit_softrst,
    input  logic                             hit_caps,
    input  logic                             hit_vid_hi,
    input  logic                             hit_vid_lo,
    output word_t                            rd_word
);
    // OR together the selected slot values.
    word_t slot_word;
    always_comb begin
        slot_word = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (slot_hit[i]) slot_word = slot_word | slot_q[i];
    end

    // Pick constant words first, otherwise the slot value (zero when unmapped).
    always_comb begin
        if (hit_softrst)     rd_word = ID_WORD;
        else if (hit_caps)   rd_word = CAPS_WORD;
        else if (hit_vid_hi) rd_word = VID_HI_WORD;
        else if (hit_vid_lo) rd_word = VID_LO_WORD;
        else                 rd_word = slot_word;
    end
endmodule

// File: rtl/cfg_regbank.sv
`timescale 1ns/1ps
// Top of the control register bank: decode, storage, read mux, registered read port.
// Assumes one bus access per cycle; a read sees state from before a same-cycle write.
module cfg_regbank
    import cfg_regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  addr,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic        mode_ext
);
    addr_t                            addr_even;
    logic [NUM_SLOTS-1:0]             slot_hit;
    logic                             hit_softrst, hit_caps, hit_vid_hi, hit_vid_lo;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
    word_t                            rd_word;

    cfg_regbank_decode u_dec (
        .addr        (addr),
        .addr_even   (addr_even),
        .slot_hit    (slot_hit),
        .hit_softrst (hit_softrst),
        .hit_caps    (hit_caps),
        .hit_vid_hi  (hit_vid_hi),
        .hit_vid_lo  (hit_vid_lo)
    );

    cfg_regbank_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .slot_hit (slot_hit),
        .soft_rst (wr_en && hit_softrst),
        .slot_q   (slot_q)
    );

    cfg_regbank_rdmux u_mux (
        .slot_hit    (slot_hit),
        .slot_q      (slot_q),
        .hit_softrst (hit_softrst),
        .hit_caps    (hit_caps),
        .hit_vid_hi  (hit_vid_hi),
        .hit_vid_lo  (hit_vid_lo),
        .rd_word     (rd_word)
    );

    // Capture the read word when a read is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_word;
    end

    // Export the mode select bit.
    assign mode_ext = slot_q[MODE_SLOT][MODE_BIT];

    // R2: identification read.
    assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr_even == ADDR_SOFTRST |=> rd_data == ID_WORD);
    // R5: capability word is constant.
    assert_caps_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr_even == ADDR_CAPS |=> rd_data == CAPS_WORD);
    // R7: mode output follows a write to the mode register.
    assert_mode_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr_even == ADDR_MODE |=> mode_ext == $past(wr_data[MODE_BIT]));
    // R11: read data holds without a read strobe.
    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && $past(rst_n) |=> $stable(rd_data));
endmodule

// File: tb/cfg_regbank_test.sv
`timescale 1ns/1ps
module cfg_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        mode_ext;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfg_regbank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .mode_ext(mode_ext)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_defaults;   // R9
        chk("R9 rd_data", rd_data, 16'h0000);
        chk("R9 mode_ext", {15'b0, mode_ext}, 16'h0000);
        rd_chk("R9 02h", 7'h02, 16'h8000);
        rd_chk("R9 26h", 7'h26, 16'h01C0);
        rd_chk("R9 2Ah", 7'h2A, 16'h0000);
        rd_chk("R9 2Ch", 7'h2C, 16'hBB80);
        rd_chk("R9 32h", 7'h32, 16'hBB80);
        rd_chk("R9 34h", 7'h34, 16'hBB80);
        rd_chk("R9 36h", 7'h36, 16'h8080);
        rd_chk("R9 38h", 7'h38, 16'h8080);
        rd_chk("R9 5Ah", 7'h5A, 16'h0000);
    endtask

    task automatic t_id;         // R2
        rd_chk("R2 id", 7'h00, 16'h00E4);
    endtask

    task automatic t_plain;      // R12
        wr(7'h02, 16'h1234); rd_chk("R12 02h", 7'h02, 16'h1234);
        wr(7'h2A, 16'hFFFF); rd_chk("R12 2Ah", 7'h2A, 16'hFFFF);
        wr(7'h2C, 16'hAC44); rd_chk("R12 2Ch", 7'h2C, 16'hAC44);
        wr(7'h36, 16'h0001); rd_chk("R12 36h", 7'h36, 16'h0001);
        wr(7'h38, 16'h5A5A); rd_chk("R12 38h", 7'h38, 16'h5A5A);
    endtask

    task automatic t_forced;     // R3
        wr(7'h32, 16'h1111); rd_chk("R3 32h", 7'h32, 16'hBB80);
        wr(7'h34, 16'h0000); rd_chk("R3 34h", 7'h34, 16'hBB80);
    endtask

    task automatic t_splice;     // R4
        wr(7'h26, 16'hFFFF); rd_chk("R4 ones", 7'h26, 16'hFDFF);
        wr(7'h26, 16'h0000); rd_chk("R4 zeros", 7'h26, 16'h01C0);
        wr(7'h26, 16'hA425); rd_chk("R4 mixed", 7'h26, 16'hA5E5);
    endtask

    task automatic t_readonly;   // R5, R6
        wr(7'h28, 16'hFFFF); rd_chk("R5 caps", 7'h28, 16'h01C3);
        wr(7'h7C, 16'h0000); rd_chk("R6 vid hi", 7'h7C, 16'h5A11);
        wr(7'h7E, 16'hFFFF); rd_chk("R6 vid lo", 7'h7E, 16'h3C01);
        rd_chk("R6 plain untouched", 7'h02, 16'h1234);
    endtask

    task automatic t_unmapped;   // R8
        wr(7'h40, 16'hFFFF); rd_chk("R8 40h", 7'h40, 16'h0000);
        wr(7'h04, 16'hBEEF); rd_chk("R8 04h", 7'h04, 16'h0000);
        rd_chk("R8 02h untouched", 7'h02, 16'h1234);
        rd_chk("R8 2Ah untouched", 7'h2A, 16'hFFFF);
    endtask

    task automatic t_alias;      // R10
        wr(7'h03, 16'h0F0F); rd_chk("R10 odd write", 7'h02, 16'h0F0F);
        rd_chk("R10 odd read", 7'h29, 16'h01C3);
        rd_chk("R10 odd id", 7'h01, 16'h00E4);
    endtask

    task automatic t_mode;       // R7
        wr(7'h5A, 16'h0001);
        chk("R7 mode set", {15'b0, mode_ext}, 16'h0001);
        rd_chk("R7 5Ah", 7'h5A, 16'h0001);
        wr(7'h5A, 16'hFFFE);
        chk("R7 mode clr", {15'b0, mode_ext}, 16'h0000);
        rd_chk("R7 5Ah full", 7'h5A, 16'hFFFE);
        wr(7'h5A, 16'h0001);
    endtask

    task automatic t_latency;    // R11
        logic [15:0] held;
        @(negedge clk);
        addr = 7'h36; wr_data = 16'h7777; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R11 old value", rd_data, 16'h0001);
        held = rd_data;
        wr(7'h36, 16'h2222);
        chk("R11 hold", rd_data, held);
        rd_chk("R11 new value", 7'h36, 16'h2222);
    endtask

    task automatic t_soft;       // R1
        wr(7'h00, 16'h5555);
        chk("R1 mode_ext", {15'b0, mode_ext}, 16'h0000);
        rd_chk("R1 02h", 7'h02, 16'h8000);
        rd_chk("R1 26h", 7'h26, 16'h01C0);
        rd_chk("R1 2Ah", 7'h2A, 16'h0000);
        rd_chk("R1 2Ch", 7'h2C, 16'hBB80);
        rd_chk("R1 36h", 7'h36, 16'h8080);
        rd_chk("R1 38h", 7'h38, 16'h8080);
        rd_chk("R1 5Ah", 7'h5A, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_defaults();
        t_id();
        t_plain();
        t_forced();
        t_splice();
        t_readonly();
        t_unmapped();
        t_alias();
        t_mode();
        t_latency();
        t_soft();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule